// File: doc/BRIEF.md
# Programmable Barrel Shifter with Shift-Amount Control

This block shifts a 16-bit word by an amount taken from one of four places, chosen by a 4-bit opcode: a 4-bit amount pin, one of two programmable 4-bit amount registers (called A and B here), or a leading-sign counter that finds how far the word must move left to be normalised. The opcode also picks the kind of shift: logical, arithmetic or rotate. The shifted word is captured in a result register on the rising clock edge, so an opcode acts only once that edge has latched it.

The amount pin is bidirectional and is modelled as an input, an output and an output enable. For the normalise opcodes the block drives the leading-sign count out on that pin, and two of them also store the count in register A or B so that a companion word can later be shifted by the same amount. The load opcodes write the pin value into A or B and leave the result register unchanged. A synchronous clear zeroes the result and both amount registers.

Top module: `shift_unit`

## Requirements
- R1: While `clr` is high at a rising edge, the result, amount register A and amount register B all become zero. A zero register then shifts by zero, so the data passes through unchanged.
- R2: Opcode 0 shifts `din` right by `sv_in`, filling with zeros. Bits moved past bit 0 are lost.
- R3: Opcode 1 shifts `din` left by `sv_in`, filling with zeros. Bits moved past bit 15 are lost.
- R4: Opcode 2 rotates `din` right by `sv_in` and opcode 3 rotates it left. Bits leaving one end come back in at the other end.
- R5: Opcodes 4 and 5 shift right and left, logically, by register A. Opcodes 6 and 7 do the same by register B. `sv_in` has no effect on these opcodes.
- R6: Opcode 8 loads `sv_in` into register A and opcode 9 loads it into register B. During both, `dout` holds its previous value.
- R7: Opcodes 10, 11 and 12 shift arithmetically right by `sv_in`, register A and register B. The vacated bits take copies of the original bit 15.
- R8: Opcode 13 shifts `din` left by its count of redundant sign bits. The count is the number of bits directly below bit 15 that equal bit 15, from 0 to 15, and an all-zero or all-one word gives 15. The count is presented on `sv_out`.
- R9: Opcode 14 does what opcode 13 does and also loads the count into register A. Opcode 15 does the same but loads register B.
- R10: `sv_oe` is high for opcodes 13 to 15 and low for all others.
- R11: `dout` changes only at a rising clock edge and reflects the opcode and data present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear of the result and both amount registers |
| op | input | 4 | Opcode selecting the shift kind and the amount source |
| din | input | 16 | Data word to shift |
| sv_in | input | 4 | Amount pin, input side |
| sv_out | output | 4 | Amount pin, output side (leading-sign count) |
| sv_oe | output | 1 | Amount pin output enable |
| dout | output | 16 | Registered shift result |

## Verification
The shifts are tried with a single bit at the top or bottom of the word, so that zero fill can be told apart from sign fill and lost bits from wrapped bits. Both end amounts, 0 and 15, are used, and negative and positive words are both sent through the arithmetic shifts. Normalisation is tried with all-zero, all-one, barely-negative and already-normal words, which separates the saturated count of 15 from smaller counts. Counts stored by the normalise opcodes and values written by the load opcodes are read back by shifting a known bit with the register-sourced opcodes, with a decoy value on `sv_in` to show that the pin is ignored.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
    typedef enum logic [3:0] {
        OP_SRL_PIN = 4'h0,
        OP_SLL_PIN = 4'h1,
        OP_ROR_PIN = 4'h2,
        OP_ROL_PIN = 4'h3,
        OP_SRL_A   = 4'h4,
        OP_SLL_A   = 4'h5,
        OP_SRL_B   = 4'h6,
        OP_SLL_B   = 4'h7,
        OP_LOAD_A  = 4'h8,
        OP_LOAD_B  = 4'h9,
        OP_SRA_PIN = 4'hA,
        OP_SRA_A   = 4'hB,
        OP_SRA_B   = 4'hC,
        OP_NORM    = 4'hD,
        OP_NORM_A  = 4'hE,
        OP_NORM_B  = 4'hF
    } op_e;

    typedef enum logic [2:0] {
        K_SRL,
        K_SLL,
        K_SRA,
        K_ROR,
        K_ROL
    } kind_e;

    typedef enum logic [1:0] {
        SRC_PIN,
        SRC_A,
        SRC_B,
        SRC_LSC
    } src_e;
endpackage

// File: rtl/lead_sign_count.sv
module lead_sign_count #(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  word,
    output logic [AW-1:0] count
);
    always_comb begin
        logic run;
        run   = 1'b1;
        count = '0;
        for (int i = W - 2; i >= 0; i--) begin
            if (run && (word[i] == word[W-1])) count = count + 1'b1;
            else                               run   = 1'b0;
        end
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_unit_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  d,
    input  logic [AW-1:0] amt,
    input  kind_e         kind,
    output logic [W-1:0]  y
);
    logic [W-1:0] ror_v;
    logic [W-1:0] rol_v;

    for (genvar g = 0; g < W; g++) begin : g_rot
        localparam int GI = g;
        always_comb begin
            int up;
            int dn;
            up = (GI + int'(amt)) % W;
            dn = (GI - int'(amt) + W) % W;
            ror_v[g] = d[up];
            rol_v[g] = d[dn];
        end
    end

    always_comb begin
        unique case (kind)
            K_SRL:   y = d >> amt;
            K_SLL:   y = d << amt;
            K_SRA:   y = W'($signed(d) >>> amt);
            K_ROR:   y = ror_v;
            K_ROL:   y = rol_v;
            default: y = d;
        endcase
    end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_unit_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [3:0]    op,
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] sv_in,
    output logic [AW-1:0] sv_out,
    output logic          sv_oe,
    output logic [W-1:0]  dout
);
    typedef struct packed {
        logic [W-1:0]  res;
        logic [AW-1:0] amt_a;
        logic [AW-1:0] amt_b;
    } state_t;

    state_t state_d, state_q;
    op_e    op_v;
    kind_e  kind;
    src_e   src;
    logic   hold;
    logic [AW-1:0] lsc_cnt;
    logic [AW-1:0] amt;
    logic [W-1:0]  shifted;

    assign op_v = op_e'(op);

    lead_sign_count #(.W(W), .AW(AW)) u_lsc (
        .word  (din),
        .count (lsc_cnt)
    );

    always_comb begin
        kind = K_SRL;
        src  = SRC_PIN;
        hold = 1'b0;
        unique case (op_v)
            OP_SRL_PIN: begin kind = K_SRL; src = SRC_PIN; end
            OP_SLL_PIN: begin kind = K_SLL; src = SRC_PIN; end
            OP_ROR_PIN: begin kind = K_ROR; src = SRC_PIN; end
            OP_ROL_PIN: begin kind = K_ROL; src = SRC_PIN; end
            OP_SRL_A:   begin kind = K_SRL; src = SRC_A;   end
            OP_SLL_A:   begin kind = K_SLL; src = SRC_A;   end
            OP_SRL_B:   begin kind = K_SRL; src = SRC_B;   end
            OP_SLL_B:   begin kind = K_SLL; src = SRC_B;   end
            OP_LOAD_A,
            OP_LOAD_B:  hold = 1'b1;
            OP_SRA_PIN: begin kind = K_SRA; src = SRC_PIN; end
            OP_SRA_A:   begin kind = K_SRA; src = SRC_A;   end
            OP_SRA_B:   begin kind = K_SRA; src = SRC_B;   end
            default:    begin kind = K_SLL; src = SRC_LSC; end
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_PIN: amt = sv_in;
            SRC_A:   amt = state_q.amt_a;
            SRC_B:   amt = state_q.amt_b;
            default: amt = lsc_cnt;
        endcase
    end

    shift_core #(.W(W), .AW(AW)) u_core (
        .d    (din),
        .amt  (amt),
        .kind (kind),
        .y    (shifted)
    );

    always_comb begin
        state_d = state_q;
        if (clr) begin
            state_d = '0;
        end else begin
            if (!hold) state_d.res = shifted;
            if (op_v == OP_LOAD_A) state_d.amt_a = sv_in;
            if (op_v == OP_LOAD_B) state_d.amt_b = sv_in;
            if (op_v == OP_NORM_A) state_d.amt_a = lsc_cnt;
            if (op_v == OP_NORM_B) state_d.amt_b = lsc_cnt;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign sv_oe  = (src == SRC_LSC);
    assign sv_out = lsc_cnt;
    assign dout   = state_q.res;

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        clr |=> (dout == '0 && state_q.amt_a == '0 && state_q.amt_b == '0));

    // R6
    load_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (op == 4'h8 || op == 4'h9) |=> $stable(dout));

    // R7
    sra_sign_chk: assert property (@(posedge clk) disable iff (clr)
        (op == 4'hA || op == 4'hB || op == 4'hC) |=> dout[W-1] == $past(din[W-1]));

    // R8
    norm_msb_chk: assert property (@(posedge clk) disable iff (clr)
        (op >= 4'hD && din != '0 && din != '1) |=> dout[W-1] != dout[W-2]);

    // R9
    norm_load_a_chk: assert property (@(posedge clk) disable iff (clr)
        (op == 4'hE) |=> state_q.amt_a == $past(lsc_cnt));

    // R2
    srl_msb_chk: assert property (@(posedge clk) disable iff (clr)
        (op == 4'h0 && sv_in != '0) |=> dout[W-1] == 1'b0);
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
    logic        clk = 1'b0;
    logic        clr;
    logic [3:0]  op;
    logic [15:0] din;
    logic [3:0]  sv_in;
    logic [3:0]  sv_out;
    logic        sv_oe;
    logic [15:0] dout;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    shift_unit u_shift_unit (
        .clk(clk), .clr(clr), .op(op), .din(din), .sv_in(sv_in),
        .sv_out(sv_out), .sv_oe(sv_oe), .dout(dout)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(logic [3:0] o, logic [15:0] d, logic [3:0] s);
        @(negedge clk);
        op = o; din = d; sv_in = s;
        @(posedge clk);
        #1;
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr = 1'b1; op = 4'h0; din = 16'hFFFF; sv_in = 4'h0;
        @(posedge clk); #1;
        clr = 1'b0;
        check("R1 result", dout, 16'h0000);
        step(4'h4, 16'hA5C3, 4'h7);
        check("R1 regA zero", dout, 16'hA5C3);
        step(4'h6, 16'h5A3C, 4'h9);
        check("R1 regB zero", dout, 16'h5A3C);
    endtask

    task automatic t_timing();
        step(4'h0, 16'h1234, 4'h0);
        @(negedge clk);
        op = 4'h1; din = 16'h0001; sv_in = 4'h3;
        #1;
        check("R11 before edge", dout, 16'h1234);
        @(posedge clk); #1;
        check("R11 after edge", dout, 16'h0008);
    endtask

    task automatic t_srl();
        step(4'h0, 16'h8001, 4'h4);
        check("R2 srl4", dout, 16'h0800);
        step(4'h0, 16'hF000, 4'hF);
        check("R2 srl15", dout, 16'h0001);
    endtask

    task automatic t_sll();
        step(4'h1, 16'h8001, 4'h1);
        check("R3 sll1", dout, 16'h0002);
        step(4'h1, 16'h00FF, 4'h8);
        check("R3 sll8", dout, 16'hFF00);
    endtask

    task automatic t_rot();
        step(4'h2, 16'h0001, 4'h1);
        check("R4 ror1", dout, 16'h8000);
        step(4'h3, 16'h8001, 4'h4);
        check("R4 rol4", dout, 16'h0018);
        step(4'h2, 16'h1234, 4'h0);
        check("R4 ror0", dout, 16'h1234);
    endtask

    task automatic t_load_and_reg();
        step(4'h0, 16'h1234, 4'h0);
        step(4'h8, 16'hFFFF, 4'h3);
        check("R6 hold A", dout, 16'h1234);
        check("R10 oe load", {15'b0, sv_oe}, 16'h0000);
        step(4'h9, 16'hFFFF, 4'h5);
        check("R6 hold B", dout, 16'h1234);
        step(4'h4, 16'h8000, 4'hF);
        check("R5 srl A", dout, 16'h1000);
        step(4'h5, 16'h0001, 4'hF);
        check("R5 sll A", dout, 16'h0008);
        step(4'h6, 16'h8000, 4'h0);
        check("R5 srl B", dout, 16'h0400);
        step(4'h7, 16'h0003, 4'h1);
        check("R5 sll B", dout, 16'h0060);
    endtask

    task automatic t_sra();
        step(4'hA, 16'h8000, 4'h4);
        check("R7 sra neg", dout, 16'hF800);
        step(4'hA, 16'h4000, 4'h2);
        check("R7 sra pos", dout, 16'h1000);
        step(4'hB, 16'hF0F0, 4'h0);
        check("R7 sra A", dout, 16'hFE1E);
        step(4'hC, 16'h7FFF, 4'h0);
        check("R7 sra B", dout, 16'h03FF);
    endtask

    task automatic norm_case(logic [15:0] d, logic [3:0] cnt, logic [15:0] res);
        @(negedge clk);
        op = 4'hD; din = d; sv_in = 4'h0;
        #1;
        check("R8 count", {12'b0, sv_out}, {12'b0, cnt});
        check("R10 oe norm", {15'b0, sv_oe}, 16'h0001);
        @(posedge clk); #1;
        check("R8 result", dout, res);
    endtask

    task automatic t_norm();
        norm_case(16'h0001, 4'd14, 16'h4000);
        norm_case(16'h0000, 4'd15, 16'h0000);
        norm_case(16'hFFFF, 4'd15, 16'h8000);
        norm_case(16'hC000, 4'd1,  16'h8000);
        norm_case(16'h4000, 4'd0,  16'h4000);
    endtask

    task automatic t_norm_load();
        step(4'hE, 16'h0010, 4'h0);
        check("R9 norm A result", dout, 16'h4000);
        step(4'h4, 16'h8000, 4'h1);
        check("R9 regA count", dout, 16'h0020);
        step(4'hF, 16'hFF00, 4'h0);
        check("R9 norm B result", dout, 16'h8000);
        step(4'h6, 16'h8000, 4'h1);
        check("R9 regB count", dout, 16'h0100);
    endtask

    task automatic t_oe_all();
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            op = 4'(k); din = 16'h0000; sv_in = 4'h0;
            #1;
            check("R10 oe", {15'b0, sv_oe}, {15'b0, (k >= 13)});
        end
    endtask

    initial begin : watchdog
        #200000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        clr = 1'b1; op = 4'h0; din = '0; sv_in = '0;
        repeat (2) @(posedge clk);
        t_clear();
        t_timing();
        t_srl();
        t_sll();
        t_rot();
        t_load_and_reg();
        t_sra();
        t_norm();
        t_norm_load();
        t_oe_all();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule